// File: doc/BRIEF.md
# I2C Target with General-Call Decoding

This block is the target (slave) side of an I2C bus. It passes SCL and SDA through a synchroniser and detects start, repeated-start and stop conditions. It compares the first byte of each transfer with a 7-bit own address. On a match it acknowledges the byte. It then either receives data bytes or shifts transmit data onto SDA, depending on the direction bit. SDA is open drain, so the block only asserts `sda_oe` to pull the line low.

General calls (address byte 0x00) are acknowledged only when they are enabled. The command byte that follows a general call is decoded into a status flag and a two-bit ID:

- 0x06 resets the bit engine.
- 0x04 leaves the engine running.
- With the hardware general-call option enabled, a byte equal to the `alt_id` input is also recognised.

Software can choose whether the transmit request pulse fires early, on the SCL rising edge of the acknowledge clock, or late, on the following falling edge. Start and repeated-start flags clear on a stop. The general-call status clears through a write-one-to-clear input.

Top module: `i2c_gc_target`

## Requirements
- R1: An address byte whose upper seven bits equal `own_addr` is acknowledged (SDA held low through the ninth clock). Any other address byte, except an enabled general call, is not acknowledged. Address bit 0 is the direction: 0 means write to the target, 1 means read from it.
- R2: While `slv_en` is 0 the block recognises no address and never asserts `sda_oe`.
- R3: In an addressed write, each 8-bit byte is received MSB first and acknowledged. It appears on `rx_data` together with a one-cycle `rx_irq` pulse.
- R4: In an addressed read, `tx_data` is shifted out MSB first. A further byte follows only when the controller acknowledges. After a NACK the target stops driving SDA.
- R5: `tx_irq` pulses for one cycle once per transmitted byte. With `early_tx`=1 it pulses while SCL is high in the acknowledge clock before the byte. With `early_tx`=0 it pulses after that clock's falling edge, while SCL is low.
- R6: `sta_flag` sets on a start followed by a matching address, on a start byte 0x01 (which is not acknowledged), or on an enabled general call. It clears on a stop.
- R7: `reps_flag` sets when a start arrives without an intervening stop, and clears on a stop.
- R8: Address byte 0x00 is acknowledged only when `gc_en`=1.
- R9: A general-call command byte 0x04 is acknowledged. It sets `gc_flag` with `gc_id`=2'b10, and later bytes are still received as data.
- R10: A general-call command byte 0x06 is acknowledged. It sets `gc_flag` with `gc_id`=2'b01, then returns the bit engine to idle, so the next byte of that transfer is not acknowledged.
- R11: With `hgc_en`=1 and `gc_en`=1, a command byte equal to `alt_id` is acknowledged and gives `gc_id`=2'b11. With `hgc_en`=0 the same byte is not acknowledged and sets no status.
- R12: A one-cycle pulse on `gc_clr` clears `gc_flag` and `gc_id`. While `gc_clr` is 0 both hold their value, including across a stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | Pull SDA low when 1 |
| slv_en | input | 1 | Target enable |
| gc_en | input | 1 | General-call enable |
| hgc_en | input | 1 | Hardware general-call enable |
| early_tx | input | 1 | Transmit request on SCL rise (1) or fall (0) |
| gc_clr | input | 1 | Write-one-to-clear for general-call status |
| own_addr | input | 7 | Own 7-bit address |
| alt_id | input | 8 | Alternate ID compared in hardware general call |
| tx_data | input | 8 | Byte to transmit, sampled at the start of each byte |
| rx_data | output | 8 | Last received data byte |
| rx_irq | output | 1 | One-cycle receive pulse |
| tx_irq | output | 1 | One-cycle transmit request pulse |
| sta_flag | output | 1 | Start/addressed status |
| reps_flag | output | 1 | Repeated-start status |
| gc_flag | output | 1 | General-call status |
| gc_id | output | 2 | General-call ID: 00 none, 01 reset, 10 reprogram, 11 hardware |

## Verification
A bit counter or shift register that is off by one shows up within the same byte:

- In a write, the acknowledge lands on the wrong clock, so the controller samples a NACK.
- In a read, the byte the controller collects is rotated or corrupted.

A mis-decoded general-call command shows within a few cycles of the eighth rising edge, as a wrong `gc_id` or a wrong acknowledge on that byte. A 0x06 reset that fails to return the engine to idle shows one byte later, when the following byte is wrongly acknowledged. Stale start or repeated-start state shows as a flag that remains set after the stop.

// File: rtl/i2c_gc_pkg.sv
package i2c_gc_pkg;
   localparam int BYTE_W = 8;
   localparam int ADDR_W = BYTE_W - 1;
   localparam int CNT_W  = $clog2(BYTE_W + 1);

   typedef enum logic [2:0] {
      ST_IDLE, ST_ADDR, ST_AACK, ST_RX, ST_TX, ST_TACK
   } eng_st_e;

   localparam logic [1:0] GCID_NONE = 2'b00;
   localparam logic [1:0] GCID_RST  = 2'b01;
   localparam logic [1:0] GCID_PROG = 2'b10;
   localparam logic [1:0] GCID_HW   = 2'b11;

   localparam logic [BYTE_W-1:0] CMD_RST    = 8'h06;
   localparam logic [BYTE_W-1:0] CMD_PROG   = 8'h04;
   localparam logic [BYTE_W-1:0] BYTE_START = 8'h01;
   localparam logic [BYTE_W-1:0] BYTE_GC    = 8'h00;
endpackage

// File: rtl/i2c_gc_sync.sv
module i2c_gc_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_evt,
   output logic stop_evt
);
   logic [STAGES-1:0] scl_p, sda_p;
   logic scl_q, sda_q, scl_s;

   for (genvar i = 0; i < STAGES; i++) begin : g_stg
      if (i == 0) begin : g_in
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) begin
               scl_p[i] <= 1'b1;
               sda_p[i] <= 1'b1;
            end else begin
               scl_p[i] <= scl_i;
               sda_p[i] <= sda_i;
            end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) begin
               scl_p[i] <= 1'b1;
               sda_p[i] <= 1'b1;
            end else begin
               scl_p[i] <= scl_p[i-1];
               sda_p[i] <= sda_p[i-1];
            end
      end
   end

   assign scl_s = scl_p[STAGES-1];
   assign sda_s = sda_p[STAGES-1];

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end

   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_gc_engine.sv
module i2c_gc_engine
   import i2c_gc_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sda_s,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_evt,
   input  logic              stop_evt,
   input  logic              slv_en,
   input  logic              gc_en,
   input  logic              hgc_en,
   input  logic              early_tx,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic [BYTE_W-1:0] alt_id,
   input  logic [BYTE_W-1:0] tx_data,
   output logic              sda_oe,
   output logic [BYTE_W-1:0] rx_data,
   output logic              rx_irq,
   output logic              tx_irq,
   output logic              addr_hit,
   output logic              gc_evt,
   output logic [1:0]        gc_code
);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
   localparam logic [CNT_W-1:0] ALL_BITS = CNT_W'(BYTE_W);

   eng_st_e           st;
   logic [CNT_W-1:0]  bcnt;
   logic [BYTE_W-2:0] sh, txsh;
   logic              rd_mode, gc_first, rst_pend, ack_pend, mack;
   logic [BYTE_W-1:0] byte_in;

   assign byte_in = {sh, sda_s};

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         st <= ST_IDLE; bcnt <= '0; sh <= '0; txsh <= '0;
         rd_mode <= 1'b0; gc_first <= 1'b0; rst_pend <= 1'b0;
         ack_pend <= 1'b0; mack <= 1'b0; sda_oe <= 1'b0;
         rx_data <= '0; rx_irq <= 1'b0; tx_irq <= 1'b0;
         addr_hit <= 1'b0; gc_evt <= 1'b0; gc_code <= GCID_NONE;
      end else begin
         rx_irq <= 1'b0; tx_irq <= 1'b0; addr_hit <= 1'b0; gc_evt <= 1'b0;
         if (!slv_en || stop_evt) begin
            st <= ST_IDLE; sda_oe <= 1'b0; ack_pend <= 1'b0; rst_pend <= 1'b0;
         end else if (start_evt) begin
            st <= ST_ADDR; bcnt <= '0; sda_oe <= 1'b0; ack_pend <= 1'b0;
            gc_first <= 1'b0; rst_pend <= 1'b0;
         end else begin
            case (st)
               ST_ADDR, ST_RX: begin
                  if (scl_rise) begin
                     sh <= byte_in[BYTE_W-2:0];
                     if (bcnt == LAST_BIT) begin
                        bcnt <= '0;
                        if (st == ST_ADDR) begin
                           if (byte_in == BYTE_GC && gc_en) begin
                              ack_pend <= 1'b1; gc_first <= 1'b1;
                              rd_mode <= 1'b0; addr_hit <= 1'b1;
                           end else if (byte_in[BYTE_W-1:1] == own_addr) begin
                              ack_pend <= 1'b1; rd_mode <= byte_in[0];
                              addr_hit <= 1'b1;
                           end else begin
                              addr_hit <= (byte_in == BYTE_START);
                              st <= ST_IDLE;
                           end
                        end else if (gc_first) begin
                           gc_first <= 1'b0;
                           if (hgc_en && gc_en && byte_in == alt_id) begin
                              gc_evt <= 1'b1; gc_code <= GCID_HW; ack_pend <= 1'b1;
                           end else if (byte_in == CMD_RST) begin
                              gc_evt <= 1'b1; gc_code <= GCID_RST; ack_pend <= 1'b1;
                              rst_pend <= 1'b1;
                           end else if (byte_in == CMD_PROG) begin
                              gc_evt <= 1'b1; gc_code <= GCID_PROG; ack_pend <= 1'b1;
                           end else begin
                              st <= ST_IDLE;
                           end
                        end else begin
                           rx_data <= byte_in; rx_irq <= 1'b1; ack_pend <= 1'b1;
                        end
                     end else begin
                        bcnt <= bcnt + 1'b1;
                     end
                  end
                  if (scl_fall && ack_pend) begin
                     sda_oe <= 1'b1; ack_pend <= 1'b0; st <= ST_AACK;
                  end
               end
               ST_AACK: begin
                  if (scl_rise && rd_mode && early_tx) tx_irq <= 1'b1;
                  if (scl_fall) begin
                     sda_oe <= 1'b0; bcnt <= '0;
                     if (rst_pend) begin
                        st <= ST_IDLE; rst_pend <= 1'b0; sh <= '0;
                     end else if (rd_mode) begin
                        st <= ST_TX; txsh <= tx_data[BYTE_W-2:0];
                        sda_oe <= ~tx_data[BYTE_W-1];
                        if (!early_tx) tx_irq <= 1'b1;
                     end else begin
                        st <= ST_RX;
                     end
                  end
               end
               ST_TX: begin
                  if (scl_rise) bcnt <= bcnt + 1'b1;
                  if (scl_fall) begin
                     if (bcnt == ALL_BITS) begin
                        sda_oe <= 1'b0; bcnt <= '0; st <= ST_TACK;
                     end else begin
                        txsh <= {txsh[BYTE_W-3:0], 1'b0};
                        sda_oe <= ~txsh[BYTE_W-2];
                     end
                  end
               end
               ST_TACK: begin
                  if (scl_rise) begin
                     mack <= ~sda_s;
                     if (!sda_s && early_tx) tx_irq <= 1'b1;
                  end
                  if (scl_fall) begin
                     if (mack) begin
                        st <= ST_TX; txsh <= tx_data[BYTE_W-2:0];
                        sda_oe <= ~tx_data[BYTE_W-1];
                        if (!early_tx) tx_irq <= 1'b1;
                     end else begin
                        st <= ST_IDLE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
endmodule

// File: rtl/i2c_gc_status.sv
module i2c_gc_status (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_evt,
   input  logic       stop_evt,
   input  logic       addr_hit,
   input  logic       gc_evt,
   input  logic [1:0] gc_code,
   input  logic       gc_clr,
   output logic       sta_flag,
   output logic       reps_flag,
   output logic       gc_flag,
   output logic [1:0] gc_id
);
   logic busy;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         busy <= 1'b0; sta_flag <= 1'b0; reps_flag <= 1'b0;
         gc_flag <= 1'b0; gc_id <= 2'b00;
      end else begin
         if (stop_evt) begin
            busy <= 1'b0; sta_flag <= 1'b0; reps_flag <= 1'b0;
         end else begin
            if (start_evt) begin
               busy <= 1'b1;
               if (busy) reps_flag <= 1'b1;
            end
            if (addr_hit) sta_flag <= 1'b1;
         end
         if (gc_evt) begin
            gc_flag <= 1'b1; gc_id <= gc_code;
         end else if (gc_clr) begin
            gc_flag <= 1'b0; gc_id <= 2'b00;
         end
      end
endmodule

// File: rtl/i2c_gc_target.sv
module i2c_gc_target
   import i2c_gc_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   input  logic              slv_en,
   input  logic              gc_en,
   input  logic              hgc_en,
   input  logic              early_tx,
   input  logic              gc_clr,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic [BYTE_W-1:0] alt_id,
   input  logic [BYTE_W-1:0] tx_data,
   output logic [BYTE_W-1:0] rx_data,
   output logic              rx_irq,
   output logic              tx_irq,
   output logic              sta_flag,
   output logic              reps_flag,
   output logic              gc_flag,
   output logic [1:0]        gc_id
);
   initial begin : p_param_chk
      assert (SYNC_STAGES >= 2) else $fatal(1, "SYNC_STAGES must be at least 2");
   end

   logic sda_s, scl_rise, scl_fall, start_evt, stop_evt;
   logic addr_hit, gc_evt;
   logic [1:0] gc_code;

   i2c_gc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_evt(start_evt), .stop_evt(stop_evt)
   );

   i2c_gc_engine u_eng (
      .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
      .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt),
      .slv_en(slv_en), .gc_en(gc_en), .hgc_en(hgc_en), .early_tx(early_tx),
      .own_addr(own_addr), .alt_id(alt_id), .tx_data(tx_data),
      .sda_oe(sda_oe), .rx_data(rx_data), .rx_irq(rx_irq), .tx_irq(tx_irq),
      .addr_hit(addr_hit), .gc_evt(gc_evt), .gc_code(gc_code)
   );

   i2c_gc_status u_stat (
      .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .stop_evt(stop_evt),
      .addr_hit(addr_hit), .gc_evt(gc_evt), .gc_code(gc_code), .gc_clr(gc_clr),
      .sta_flag(sta_flag), .reps_flag(reps_flag), .gc_flag(gc_flag), .gc_id(gc_id)
   );
endmodule

// File: rtl/i2c_gc_checker.sv
module i2c_gc_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       slv_en,
   input logic       sda_oe,
   input logic       start_evt,
   input logic       stop_evt,
   input logic       sta_flag,
   input logic       reps_flag,
   input logic       gc_clr,
   input logic       gc_evt,
   input logic [1:0] gc_code,
   input logic       gc_flag,
   input logic [1:0] gc_id,
   input logic       rx_irq,
   input logic       tx_irq
);
   AST_OE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (!slv_en && $past(!slv_en)) |-> !sda_oe); // R2
   AST_RXIRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_irq |=> !rx_irq); // R3
   AST_TXIRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      tx_irq |=> !tx_irq); // R5
   AST_STA_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      $past(stop_evt) |-> !sta_flag); // R6
   AST_REPS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      $past(stop_evt) |-> !reps_flag); // R7
   AST_REPS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(reps_flag) |-> $past(start_evt)); // R7
   AST_GC_RST_ID: assert property (@(posedge clk) disable iff (!rst_n)
      $past(gc_evt && gc_code == 2'b01) |-> (gc_flag && gc_id == 2'b01)); // R10
   AST_GC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      $past(gc_clr && !gc_evt) |-> (!gc_flag && gc_id == 2'b00)); // R12
endmodule

bind i2c_gc_target i2c_gc_checker u_chk (
   .clk(clk), .rst_n(rst_n), .slv_en(slv_en), .sda_oe(sda_oe),
   .start_evt(start_evt), .stop_evt(stop_evt), .sta_flag(sta_flag),
   .reps_flag(reps_flag), .gc_clr(gc_clr), .gc_evt(gc_evt), .gc_code(gc_code),
   .gc_flag(gc_flag), .gc_id(gc_id), .rx_irq(rx_irq), .tx_irq(tx_irq)
);

// File: tb/i2c_gc_target_bench.sv
module i2c_gc_target_bench;
   localparam int Q = 4;
   localparam logic [6:0] OWN = 7'h2A;

   logic clk = 1'b0, rst_n = 1'b0;
   logic scl_m = 1'b1, sda_m = 1'b1;
   logic slv_en = 1'b0, gc_en = 1'b0, hgc_en = 1'b0, early_tx = 1'b0, gc_clr = 1'b0;
   logic [7:0] alt_id = 8'h55, tx_data = 8'h00;
   logic sda_oe, rx_irq, tx_irq, sta_flag, reps_flag, gc_flag;
   logic [7:0] rx_data;
   logic [1:0] gc_id;
   logic sda_line;

   int n_chk = 0, n_err = 0;
   int oe_cnt = 0, tx_hi = 0, tx_lo = 0;
   logic [7:0] exp_rx [$];

   assign sda_line = sda_m & ~sda_oe;

   always #2 clk = ~clk;

   i2c_gc_target u_i2c_gc_target (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
      .slv_en(slv_en), .gc_en(gc_en), .hgc_en(hgc_en), .early_tx(early_tx),
      .gc_clr(gc_clr), .own_addr(OWN), .alt_id(alt_id), .tx_data(tx_data),
      .rx_data(rx_data), .rx_irq(rx_irq), .tx_irq(tx_irq), .sta_flag(sta_flag),
      .reps_flag(reps_flag), .gc_flag(gc_flag), .gc_id(gc_id)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // monitor: scoreboard for received bytes and event counters
   always @(negedge clk) begin
      if (sda_oe) oe_cnt++;
      if (tx_irq) begin
         if (scl_m) tx_hi++; else tx_lo++;
      end
      if (rx_irq) begin
         if (exp_rx.size() == 0) chk("R3 unexpected rx byte", {24'd0, rx_data}, 32'hFFFF_FFFF);
         else chk("R3 rx byte", {24'd0, rx_data}, {24'd0, exp_rx.pop_front()});
      end
   end

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic m_start();
      sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(2*Q);
      sda_m = 1'b0; tick(2*Q); scl_m = 1'b0; tick(Q);
   endtask

   task automatic m_stop();
      sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(2*Q); sda_m = 1'b1; tick(2*Q);
   endtask

   task automatic m_bit(input logic b, output logic r);
      sda_m = b; tick(Q); scl_m = 1'b1; tick(Q); r = sda_line; tick(Q);
      scl_m = 1'b0; tick(Q);
   endtask

   task automatic m_byte(input logic [7:0] d, output logic ack);
      logic r;
      for (int i = 7; i >= 0; i--) m_bit(d[i], r);
      m_bit(1'b1, r);
      ack = ~r;
   endtask

   // driver for write data: expected bytes go to the scoreboard queue
   task automatic m_wdata(input logic [7:0] d, output logic ack);
      exp_rx.push_back(d);
      m_byte(d, ack);
   endtask

   task automatic m_read(input logic give_ack, input logic [7:0] nxt, output logic [7:0] d);
      logic r;
      d = '0;
      for (int i = 0; i < 8; i++) begin
         m_bit(1'b1, r);
         d = {d[6:0], r};
      end
      tx_data = nxt;
      m_bit(~give_ack, r);
   endtask

   task automatic pulse_clr();
      gc_clr = 1'b1; tick(1); gc_clr = 1'b0; tick(1);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
   end

   initial begin : main
      logic ack;
      logic [7:0] d;
      tick(5);
      rst_n = 1'b1;
      tick(2);
      chk("R6 reset sta", sta_flag, 0);
      chk("R7 reset reps", reps_flag, 0);
      chk("R12 reset gc", {gc_flag, gc_id}, 0);
      chk("R2 reset oe", sda_oe, 0);

      // R2: disabled target ignores own address
      oe_cnt = 0;
      m_start(); m_byte({OWN, 1'b0}, ack); m_stop();
      chk("R2 no ack while disabled", ack, 0);
      chk("R2 sda never driven", oe_cnt, 0);
      chk("R2 sta stays clear", sta_flag, 0);

      slv_en = 1'b1; tick(2);
      // R1 / R3 / R6: addressed write
      m_start(); m_byte({OWN, 1'b0}, ack);
      chk("R1 own address acked", ack, 1);
      chk("R6 sta after match", sta_flag, 1);
      m_wdata(8'hA5, ack); chk("R3 byte0 acked", ack, 1);
      m_wdata(8'h3C, ack); chk("R3 byte1 acked", ack, 1);
      m_stop();
      chk("R6 sta cleared by stop", sta_flag, 0);
      chk("R3 all bytes seen", exp_rx.size(), 0);

      // R1: wrong address
      m_start(); m_byte({7'h2B, 1'b0}, ack); m_stop();
      chk("R1 foreign address not acked", ack, 0);

      // R4 / R5: read, late request
      early_tx = 1'b0; tx_hi = 0; tx_lo = 0; tx_data = 8'hC3;
      m_start(); m_byte({OWN, 1'b1}, ack);
      chk("R1 read address acked", ack, 1);
      m_read(1'b1, 8'h5E, d); chk("R4 read byte0", d, 8'hC3);
      m_read(1'b0, 8'hFF, d); chk("R4 read byte1", d, 8'h5E);
      oe_cnt = 0;
      m_byte(8'hFF, ack);
      chk("R4 no drive after nack", oe_cnt, 0);
      m_stop();
      chk("R5 late pulses low", tx_lo, 2);
      chk("R5 late no high pulse", tx_hi, 0);

      // R5: early request
      early_tx = 1'b1; tx_hi = 0; tx_lo = 0; tx_data = 8'h81;
      m_start(); m_byte({OWN, 1'b1}, ack);
      m_read(1'b1, 8'h7E, d); chk("R4 early byte0", d, 8'h81);
      m_read(1'b0, 8'h00, d); chk("R4 early byte1", d, 8'h7E);
      m_stop();
      chk("R5 early pulses high", tx_hi, 2);
      chk("R5 early no low pulse", tx_lo, 0);
      early_tx = 1'b0;

      // R7: repeated start
      m_start(); m_byte({OWN, 1'b0}, ack);
      chk("R7 no reps on first start", reps_flag, 0);
      m_start(); m_byte({OWN, 1'b0}, ack);
      chk("R7 reps set", reps_flag, 1);
      m_stop();
      chk("R7 reps cleared by stop", reps_flag, 0);

      // R8: general call disabled
      m_start(); m_byte(8'h00, ack); m_stop();
      chk("R8 gc nack when disabled", ack, 0);

      // R9 / R12: reprogram command
      gc_en = 1'b1;
      m_start(); m_byte(8'h00, ack);
      chk("R8 gc acked when enabled", ack, 1);
      chk("R6 sta on general call", sta_flag, 1);
      m_byte(8'h04, ack); chk("R9 cmd acked", ack, 1);
      chk("R9 gc status", {gc_flag, gc_id}, 3'b110);
      m_wdata(8'h5A, ack); chk("R9 data continues", ack, 1);
      m_stop();
      tick(4);
      chk("R12 status holds without clear", {gc_flag, gc_id}, 3'b110);
      pulse_clr();
      chk("R12 clear", {gc_flag, gc_id}, 3'b000);

      // R10: reset command
      m_start(); m_byte(8'h00, ack);
      m_byte(8'h06, ack); chk("R10 cmd acked", ack, 1);
      chk("R10 gc status", {gc_flag, gc_id}, 3'b101);
      m_byte(8'h33, ack); chk("R10 engine reset, next byte nacked", ack, 0);
      m_stop();
      pulse_clr();

      // R11: hardware general call
      hgc_en = 1'b1;
      m_start(); m_byte(8'h00, ack); m_byte(8'h55, ack); m_stop();
      chk("R11 hw match acked", ack, 1);
      chk("R11 hw status", {gc_flag, gc_id}, 3'b111);
      pulse_clr();
      hgc_en = 1'b0;
      m_start(); m_byte(8'h00, ack); m_byte(8'h55, ack); m_stop();
      chk("R11 hw disabled nack", ack, 0);
      chk("R11 hw disabled no status", {gc_flag, gc_id}, 3'b000);

      // R6: start byte
      m_start(); m_byte(8'h01, ack);
      chk("R6 start byte not acked", ack, 0);
      chk("R6 sta on start byte", sta_flag, 1);
      m_stop();
      chk("R6 sta cleared", sta_flag, 0);
      chk("R3 scoreboard drained", exp_rx.size(), 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
   end
endmodule